// File: doc/BRIEF.md
# Block-Write Serial Configuration Slave

This block is a receive-oriented slave on a two-wire serial bus. It holds a small bank of byte-wide configuration registers and presents their contents in parallel to the surrounding logic. It samples the bus clock and data lines with a fast system clock. On that clock it finds START and STOP conditions, compares the 7-bit device address and acknowledges. It then walks a byte pointer through the register bank.

A write always begins at register 0. The two bytes after the address are a command code and a byte count; both are acknowledged and thrown away, and every later byte lands in the next register. A read first returns a fixed byte count and then the registers from register 0 upward. The slave lets go of the data line after the reported number of data bytes, or as soon as the host declines a byte.

Top module: `blkcfg_slave`

## Requirements
- R1: After reset every configuration register holds its reset value (all ones by default), where cfgOut bits [8*i+7:8*i] carry register i.
- R2: An address byte of D2h (write) or D3h (read) for device address 69h is acknowledged by pulling SDA low during the ninth clock; any other address gets no acknowledge, and the slave leaves SDA alone until the next START.
- R3: In a write, the two bytes that follow the address are acknowledged and their contents change no register.
- R4: Data bytes of a write are acknowledged and stored from register 0 upward, one register per byte, most significant bit first on the wire.
- R5: A STOP after any complete data byte ends the write; registers already written keep their new values and the others keep their old ones.
- R6: A data byte cut short by a STOP before its eighth bit is discarded.
- R7: Data bytes beyond the last register are acknowledged and change nothing.
- R8: A read sends the byte count (BYTE_COUNT, 3 by default) first, then register 0, 1, ... in order, each byte most significant bit first.
- R9: After BYTE_COUNT data bytes the slave releases SDA even when the host keeps acknowledging, so further bytes read as FFh.
- R10: A host not-acknowledge on a read byte ends the read and the slave releases SDA.
- R11: A START (SDA falling while SCL is high) at any point restarts the slave at the address byte, and the slave changes its own SDA drive only while SCL is low.
- R12: Read positions past the last implemented register return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaDriveLow | output | 1 | 1 pulls the data line low, 0 releases it |
| cfgOut | output | 8*NUM_REGS | Register contents, register i in bits [8*i+7:8*i] |

## Verification
Writes are tried at full length, truncated after one byte, run past the last register, and cut off mid-byte. Comparing the register image after each one shows whether the dummy bytes, the pointer order and the drop rules are handled. Reads are tried with the host acknowledging every byte and beyond the count, and with an early not-acknowledge. These tell apart a slave that stops on count, one that stops on host refusal, and one that keeps driving. A second instance with fewer registers and another address shares the bus. It shows up address mismatches and the zero fill past the register bank, and a repeated START mid-write shows the restart at the address byte.

// File: rtl/blkcfg_pkg.sv
package blkcfg_pkg;

  // Strobes from the control sequencer to the datapath.
  typedef struct packed {
    logic       shiftIn;   // capture one received bit
    logic       bitIn;     // received bit value
    logic       wrEn;      // commit received byte to register idx
    logic       loadTx;    // load transmit shifter
    logic       loadCount; // loadTx source: byte count instead of register
    logic       shiftTx;   // advance transmit shifter by one bit
    logic [7:0] idx;       // register pointer
  } dpCtl_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_RXACK,
    S_TX,
    S_TXACK
  } seqState_t;

endpackage

// File: rtl/blkcfg_datapath.sv
module blkcfg_datapath
  import blkcfg_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int BYTE_COUNT = 3,
  parameter logic [8*NUM_REGS-1:0] RESET_VAL = '1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtl_t                dpCtl,
  output logic [7:0]            rxByte,
  output logic                  txMsb,
  output logic [8*NUM_REGS-1:0] cfgOut
);

  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);
  localparam logic [7:0] BC8 = 8'(BYTE_COUNT);

  logic [7:0] regBank [NUM_REGS];
  logic [7:0] rxShift;
  logic [7:0] txShift;
  logic       idxValid;

  assign idxValid = dpCtl.idx < NREG8;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regBank[i] <= RESET_VAL[8*i +: 8];
      rxShift <= '0;
      txShift <= '0;
    end else begin
      if (dpCtl.shiftIn) rxShift <= {rxShift[6:0], dpCtl.bitIn};
      if (dpCtl.wrEn && idxValid) regBank[dpCtl.idx[IW-1:0]] <= rxShift;
      if (dpCtl.loadTx) begin
        if (dpCtl.loadCount) txShift <= BC8;
        else if (idxValid)   txShift <= regBank[dpCtl.idx[IW-1:0]];
        else                 txShift <= 8'h00;
      end else if (dpCtl.shiftTx) begin
        txShift <= {txShift[6:0], 1'b0};
      end
    end
  end

  assign rxByte = rxShift;
  assign txMsb  = txShift[7];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gOut
    assign cfgOut[8*g +: 8] = regBank[g];
  end

  // R4 / R7: the sequencer never asks for a write outside the bank
  a_r7_write_in_range: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.wrEn |-> (dpCtl.idx < NREG8));

  // R3: without a write strobe the register image holds
  a_r3_regs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtl.wrEn |=> $stable(cfgOut));

endmodule

// File: rtl/blkcfg_ctrl.sv
module blkcfg_ctrl
  import blkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NUM_REGS = 3,
  parameter int BYTE_COUNT = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output dpCtl_t     dpCtl,
  output logic       sdaLow
);

  localparam logic [7:0] NREG8 = 8'(NUM_REGS);
  localparam logic [7:0] BC8 = 8'(BYTE_COUNT);
  localparam logic [7:0] FIRST_DATA = 8'd3; // address, command, count precede data

  logic [1:0] sclMeta, sdaMeta;
  logic       sclPrev, sdaPrev;
  logic       sclHigh, sdaNow;
  logic       startDet, stopDet, sclRise, sclFall;

  seqState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] byteNum;
  logic [7:0] txNum;
  logic       isRead, hostAck, ackLow, txActive;
  logic       byteDone;

  // two-flop synchronizers plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclMeta <= 2'b11;
      sdaMeta <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclMeta <= {sclMeta[0], sclIn};
      sdaMeta <= {sdaMeta[0], sdaIn};
      sclPrev <= sclMeta[1];
      sdaPrev <= sdaMeta[1];
    end
  end

  assign sclHigh  = sclMeta[1];
  assign sdaNow   = sdaMeta[1];
  assign startDet = sclHigh & sclPrev & sdaPrev & ~sdaNow;
  assign stopDet  = sclHigh & sclPrev & ~sdaPrev & sdaNow;
  assign sclRise  = sclHigh & ~sclPrev;
  assign sclFall  = ~sclHigh & sclPrev;
  assign byteDone = (state == S_RX) && sclFall && (bitCnt == 4'd8);

  always_comb begin
    dpCtl           = '0;
    dpCtl.bitIn     = sdaNow;
    dpCtl.shiftIn   = (state == S_RX) && sclRise && (bitCnt < 4'd8);
    dpCtl.idx       = (state == S_TXACK) ? txNum : (byteNum - FIRST_DATA);
    dpCtl.wrEn      = byteDone && (byteNum >= FIRST_DATA) &&
                      ((byteNum - FIRST_DATA) < NREG8);
    dpCtl.loadCount = (state == S_RXACK);
    dpCtl.loadTx    = ((state == S_RXACK) && sclFall && isRead) ||
                      ((state == S_TXACK) && sclFall && hostAck && (txNum < BC8));
    dpCtl.shiftTx   = (state == S_TX) && sclFall && (bitCnt != 4'd7);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      byteNum  <= '0;
      txNum    <= '0;
      isRead   <= 1'b0;
      hostAck  <= 1'b0;
      ackLow   <= 1'b0;
      txActive <= 1'b0;
    end else if (startDet) begin
      state    <= S_RX;
      bitCnt   <= '0;
      byteNum  <= '0;
      txNum    <= '0;
      isRead   <= 1'b0;
      ackLow   <= 1'b0;
      txActive <= 1'b0;
    end else if (stopDet) begin
      state    <= S_IDLE;
      ackLow   <= 1'b0;
      txActive <= 1'b0;
    end else begin
      unique case (state)
        S_RX: begin
          if (sclRise && bitCnt < 4'd8) bitCnt <= bitCnt + 4'd1;
          if (byteDone) begin
            if (byteNum == 8'd0 && rxByte[7:1] != DEV_ADDR) begin
              state <= S_IDLE;
            end else begin
              ackLow <= 1'b1;
              state  <= S_RXACK;
              if (byteNum == 8'd0) isRead <= rxByte[0];
              if (byteNum != 8'hFF) byteNum <= byteNum + 8'd1;
            end
          end
        end
        S_RXACK: begin
          if (sclFall) begin
            ackLow <= 1'b0;
            bitCnt <= '0;
            if (isRead) begin
              txActive <= 1'b1;
              state    <= S_TX;
            end else begin
              state <= S_RX;
            end
          end
        end
        S_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              txActive <= 1'b0;
              bitCnt   <= '0;
              state    <= S_TXACK;
            end else begin
              bitCnt <= bitCnt + 4'd1;
            end
          end
        end
        S_TXACK: begin
          if (sclRise) hostAck <= ~sdaNow;
          if (sclFall) begin
            if (hostAck && txNum < BC8) begin
              txNum    <= txNum + 8'd1;
              txActive <= 1'b1;
              state    <= S_TX;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaLow = ackLow | (txActive & ~txMsb);

  // R2: an idle slave never holds the data line
  a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !sdaLow);

  // R11: own drive only moves while the bus clock is low
  a_r11_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (sclHigh && sclPrev) |-> $stable(sdaLow));

  // R9: never more data bytes than the reported count
  a_r9_tx_bound: assert property (@(posedge clk) disable iff (!rstN)
    txNum <= BC8);

  // R11: a START always returns the sequencer to the address byte
  a_r11_start_restarts: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == S_RX && byteNum == 8'd0 && !sdaLow));

endmodule

// File: rtl/blkcfg_slave.sv
module blkcfg_slave
  import blkcfg_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int BYTE_COUNT = 3,
  parameter logic [8*NUM_REGS-1:0] RESET_VAL = '1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaDriveLow,
  output logic [8*NUM_REGS-1:0] cfgOut
);

  dpCtl_t     dpCtl;
  logic [7:0] rxByte;
  logic       txMsb;

  blkcfg_ctrl #(
    .DEV_ADDR  (DEV_ADDR),
    .NUM_REGS  (NUM_REGS),
    .BYTE_COUNT(BYTE_COUNT)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .rxByte(rxByte),
    .txMsb (txMsb),
    .dpCtl (dpCtl),
    .sdaLow(sdaDriveLow)
  );

  blkcfg_datapath #(
    .NUM_REGS  (NUM_REGS),
    .BYTE_COUNT(BYTE_COUNT),
    .RESET_VAL (RESET_VAL)
  ) uData (
    .clk   (clk),
    .rstN  (rstN),
    .dpCtl (dpCtl),
    .rxByte(rxByte),
    .txMsb (txMsb),
    .cfgOut(cfgOut)
  );

endmodule

// File: tb/tb_blkcfg_slave.sv
`timescale 1ns/1ps
module tb_blkcfg_slave;

  localparam time Q = 160ns; // quarter of a bus bit time

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN;
  logic        sclHost = 1'b1;
  logic        sdaHost = 1'b1;
  logic        drvA, drvB;
  logic [23:0] cfgA;
  logic [15:0] cfgB;
  logic        sdaLine;

  assign sdaLine = sdaHost & ~drvA & ~drvB;

  blkcfg_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclHost), .sdaIn(sdaLine),
    .sdaDriveLow(drvA), .cfgOut(cfgA)
  );

  blkcfg_slave #(.NUM_REGS(2), .DEV_ADDR(7'h2A), .BYTE_COUNT(3), .RESET_VAL(16'hFFFF)) dutSmall (
    .clk(clk), .rstN(rstN), .sclIn(sclHost), .sdaIn(sdaLine),
    .sdaDriveLow(drvB), .cfgOut(cfgB)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic startCond();
    sdaHost = 1'b1; #Q;
    sclHost = 1'b1; #Q;
    sdaHost = 1'b0; #Q;
    sclHost = 1'b0; #Q;
  endtask

  task automatic stopCond();
    sdaHost = 1'b0; #Q;
    sclHost = 1'b1; #Q;
    sdaHost = 1'b1; #Q;
  endtask

  task automatic sendBit(input logic b);
    sdaHost = b; #Q;
    sclHost = 1'b1; #(2*Q);
    sclHost = 1'b0; #Q;
  endtask

  task automatic recvBit(output logic b);
    sdaHost = 1'b1; #Q;
    sclHost = 1'b1; #Q;
    b = sdaLine; #Q;
    sclHost = 1'b0; #Q;
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic bitV;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(bitV);
    ack = ~bitV;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] v);
    logic bitV;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      recvBit(bitV);
      v = {v[6:0], bitV};
    end
    sendBit(~ackIt);
  endtask

  task automatic testReset();
    check("R1 reset image main", {8'h0, cfgA}, 32'h00FFFFFF);
    check("R1 reset image small", {16'h0, cfgB}, 32'h0000FFFF);
    check("R2 no drive after reset", {30'h0, drvA, drvB}, 32'h0);
  endtask

  task automatic testWriteFull();
    logic ack;
    startCond();
    sendByte(8'hD2, ack); check("R2 write address ack", ack, 1);
    sendByte(8'h55, ack); check("R3 command ack", ack, 1);
    sendByte(8'h66, ack); check("R3 count ack", ack, 1);
    sendByte(8'h11, ack); check("R4 data0 ack", ack, 1);
    sendByte(8'h22, ack);
    sendByte(8'h33, ack); check("R4 data2 ack", ack, 1);
    stopCond();
    check("R4 register order", cfgA, 24'h332211);
    check("R3 dummy bytes discarded, small untouched", cfgB, 16'hFFFF);
  endtask

  task automatic testPartial();
    logic ack;
    startCond();
    sendByte(8'hD2, ack);
    sendByte(8'h00, ack);
    sendByte(8'h00, ack);
    sendByte(8'hA5, ack);
    stopCond();
    check("R5 stop after one byte", cfgA, 24'h3322A5);
  endtask

  task automatic testOverflow();
    logic ack;
    startCond();
    sendByte(8'hD2, ack);
    sendByte(8'h01, ack);
    sendByte(8'h02, ack);
    sendByte(8'h01, ack);
    sendByte(8'h02, ack);
    sendByte(8'h03, ack);
    sendByte(8'h04, ack); check("R7 extra byte acked", ack, 1);
    stopCond();
    check("R7 extra byte dropped", cfgA, 24'h030201);
  endtask

  task automatic testMismatch();
    logic ack;
    startCond();
    sendByte(8'h80, ack); check("R2 foreign address not acked", ack, 0);
    sendByte(8'h00, ack); check("R2 bus ignored after mismatch", ack, 0);
    sendByte(8'h00, ack); check("R2 still ignored", ack, 0);
    stopCond();
    check("R2 registers untouched", cfgA, 24'h030201);
  endtask

  task automatic testCutShort();
    logic ack;
    startCond();
    sendByte(8'hD2, ack);
    sendByte(8'h00, ack);
    sendByte(8'h00, ack);
    sendByte(8'h77, ack);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b0); sendBit(1'b1);
    stopCond();
    check("R6 partial byte discarded", cfgA, 24'h030277);
  endtask

  task automatic testRead();
    logic ack;
    logic [7:0] v;
    startCond();
    sendByte(8'hD3, ack); check("R2 read address ack", ack, 1);
    recvByte(1'b1, v); check("R8 byte count first", v, 8'h03);
    recvByte(1'b1, v); check("R8 register 0", v, 8'h77);
    recvByte(1'b1, v); check("R8 register 1", v, 8'h02);
    recvByte(1'b1, v); check("R8 register 2", v, 8'h03);
    recvByte(1'b1, v); check("R9 released after count", v, 8'hFF);
    stopCond();
  endtask

  task automatic testReadNack();
    logic ack;
    logic [7:0] v;
    startCond();
    sendByte(8'hD3, ack);
    recvByte(1'b1, v);
    recvByte(1'b0, v); check("R10 byte before nack", v, 8'h77);
    recvByte(1'b1, v); check("R10 released after nack", v, 8'hFF);
    stopCond();
  endtask

  task automatic testRepeatedStart();
    logic ack;
    startCond();
    sendByte(8'hD2, ack);
    sendByte(8'h00, ack);
    startCond();
    sendByte(8'hD2, ack); check("R11 address after repeated start", ack, 1);
    sendByte(8'h00, ack);
    sendByte(8'h00, ack);
    sendByte(8'h5A, ack);
    stopCond();
    check("R11 restart at address phase", cfgA, 24'h03025A);
  endtask

  task automatic testSmall();
    logic ack;
    logic [7:0] v;
    startCond();
    sendByte(8'h54, ack); check("R2 second instance ack", ack, 1);
    sendByte(8'h00, ack);
    sendByte(8'h00, ack);
    sendByte(8'hC1, ack);
    sendByte(8'hC2, ack);
    sendByte(8'hC3, ack); check("R7 small extra acked", ack, 1);
    stopCond();
    check("R4 small image", cfgB, 16'hC2C1);
    check("R2 main untouched", cfgA, 24'h03025A);
    startCond();
    sendByte(8'h55, ack);
    recvByte(1'b1, v); check("R8 small count", v, 8'h03);
    recvByte(1'b1, v); check("R8 small register 0", v, 8'hC1);
    recvByte(1'b1, v); check("R8 small register 1", v, 8'hC2);
    recvByte(1'b1, v); check("R12 past last register", v, 8'h00);
    stopCond();
  endtask

  initial begin
    rstN = 1'b0;
    #103;
    rstN = 1'b1;
    #(Q);
    testReset();
    testWriteFull();
    testPartial();
    testOverflow();
    testMismatch();
    testCutShort();
    testRead();
    testReadNack();
    testRepeatedStart();
    testSmall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule